// File: doc/BRIEF.md
# Two-Wire Register-Access Slave

This block is a serial slave on a two-wire bus (I2C) that gives an external bus master read and write access to a bank of 8-bit control registers. The register bank sits outside the block. The block oversamples both bus lines with the system clock, resynchronises them and finds their edges. It detects bus conditions, matches a 7-bit device address, loads a register pointer, and then moves data bytes through a simple register-file port. That port carries an address, write data, a single-cycle write strobe and read data.

The master opens a transfer with a START. It sends the device address with the direction bit, then a pointer byte, then any number of data bytes. To read, the master issues a REPEATED START after the pointer byte, then sends the address with the read bit set. The pointer advances after every data byte, so a burst reaches consecutive registers. One pointer value is decoded inside the block as a hard-wired revision register. It reads as a constant and cannot be written. The slave only ever pulls SDA low, through an output-enable.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset, `sda_oe` is 0, `reg_we` is 0 and `reg_addr` is 0x00.
- R2: A START is an SDA fall while SCL is high, and a STOP is an SDA rise while SCL is high. Both lines idle high. After a START, the first byte is taken as an address.
- R3: The slave pulls SDA low in the ninth clock of an address byte only when bits [7:1] of that byte equal `DEV_ADDR`. Bit 0 is the direction: 0 means write and 1 means read. On a mismatch it does not acknowledge and ignores all traffic until the next START.
- R4: In a write, the byte after the address is loaded into the register pointer. Each following byte produces a one-cycle `reg_we`, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. The slave acknowledges every byte.
- R5: The pointer increments by one after each data byte on both reads and writes. It wraps from 0xFF to 0x00.
- R6: Read data is sent MSB first. `sda_oe` = 1 means a 0 bit. `sda_oe` changes only while SCL is low, so SDA is stable through every SCL high phase.
- R7: If the master does not acknowledge a read byte, the slave releases SDA and drives nothing until the next START.
- R8: A REPEATED START restarts address matching without a STOP. The pointer set earlier in the transfer is kept.
- R9: A STOP at any bit position returns the slave to idle and releases SDA. A byte cut short by a STOP is never written.
- R10: A STOP that falls in the same SCL high pulse as the preceding START is ignored. The slave then still waits for an address byte.
- R11: Pointer value `REV_ADDR` (0xFF) always reads `REV_VALUE` (0x43). Writes to it produce no `reg_we`, and the value read afterwards is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line from the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_addr | output | 8 | Register pointer presented to the register bank |
| reg_wdata | output | 8 | Data byte to write |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Read data from the register bank at `reg_addr` |

## Verification
Two bus conditions can fall in one SCL high pulse: a START, followed at once by a STOP before SCL drops. The bench provokes this by raising SDA again while SCL is still high. It then clocks an address byte, a pointer and a data byte. The case is judged at the ports in two ways. The address byte must be acknowledged, which shows the STOP was dropped. The written register must read back with the new value.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_SKIP
  } xfer_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_rise,
  output logic sda_fall
);
  localparam int NL = 2;

  logic [NL-1:0] raw, lvl, rise, fall;
  assign raw = {scl_in, sda_in};

  for (genvar g = 0; g < NL; g++) begin : g_line
    logic [STAGES-1:0] chain;
    logic              prev_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        chain  <= '1;
        prev_q <= 1'b1;
      end else begin
        chain  <= {chain[STAGES-2:0], raw[g]};
        prev_q <= chain[STAGES-1];
      end
    end
    assign lvl[g]  = chain[STAGES-1];
    assign rise[g] = chain[STAGES-1] & ~prev_q;
    assign fall[g] = ~chain[STAGES-1] & prev_q;
  end

  assign scl_lvl  = lvl[1];
  assign sda_lvl  = lvl[0];
  assign scl_rise = rise[1];
  assign scl_fall = fall[1];
  assign sda_rise = rise[0];
  assign sda_fall = fall[0];
endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_lvl,
  input  logic scl_fall,
  input  logic sda_rise,
  input  logic sda_fall,
  output logic start_p,
  output logic stop_p
);
  logic start_now, start_seen;

  assign start_now = scl_lvl & sda_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_p    <= 1'b0;
      stop_p     <= 1'b0;
      start_seen <= 1'b0;
    end else begin
      start_p <= start_now;
      // a STOP inside the high pulse that carried the START is dropped
      stop_p  <= scl_lvl & sda_rise & ~start_seen;
      if (start_now)     start_seen <= 1'b1;
      else if (scl_fall) start_seen <= 1'b0;
    end
  end

  // R2: conditions are only reported for SCL high
  a_r2_cond_scl_high: assert property (@(posedge clk) disable iff (rst)
    (start_p || stop_p) |-> $past(scl_lvl));
endmodule

// File: rtl/i2c_xfer_fsm.sv
module i2c_xfer_fsm
  import i2c_slv_pkg::*;
#(
  parameter logic [6:0]        DEV_ADDR = 7'h1C,
  parameter logic [BYTE_W-1:0] REV_ADDR = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_p,
  input  logic              stop_p,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] ptr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_stb
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  xfer_state_t       state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh, tx;
  logic              rw, nack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      sh      <= '0;
      tx      <= '0;
      rw      <= 1'b0;
      nack    <= 1'b0;
      sda_oe  <= 1'b0;
      ptr     <= '0;
      wr_data <= '0;
      wr_stb  <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      if (start_p) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_p) begin
        state  <= ST_IDLE;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (scl_rise) begin
        unique case (state)
          ST_ADDR, ST_PTR, ST_WR: begin
            sh  <= {sh[BYTE_W-2:0], sda_lvl};
            cnt <= cnt + 1'b1;
          end
          ST_RD:     cnt  <= cnt + 1'b1;
          ST_RD_ACK: nack <= sda_lvl;
          default: ;
        endcase
      end else if (scl_fall) begin
        unique case (state)
          ST_ADDR: if (cnt == FULL) begin
            if (sh[BYTE_W-1:1] == DEV_ADDR) begin
              sda_oe <= 1'b1;
              rw     <= sh[0];
              state  <= ST_ADDR_ACK;
            end else begin
              state  <= ST_SKIP;
            end
          end
          ST_ADDR_ACK: begin
            cnt <= '0;
            if (rw) begin
              tx     <= rd_byte;
              sda_oe <= ~rd_byte[BYTE_W-1];
              state  <= ST_RD;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_PTR;
            end
          end
          ST_PTR: if (cnt == FULL) begin
            ptr    <= sh;
            sda_oe <= 1'b1;
            state  <= ST_PTR_ACK;
          end
          ST_PTR_ACK: begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            state  <= ST_WR;
          end
          ST_WR: if (cnt == FULL) begin
            sda_oe <= 1'b1;
            state  <= ST_WR_ACK;
            if (ptr != REV_ADDR) begin
              wr_stb  <= 1'b1;
              wr_data <= sh;
            end
          end
          ST_WR_ACK: begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            ptr    <= ptr + 1'b1;
            state  <= ST_WR;
          end
          ST_RD: begin
            if (cnt == FULL) begin
              sda_oe <= 1'b0;
              ptr    <= ptr + 1'b1;
              state  <= ST_RD_ACK;
            end else begin
              sda_oe <= ~tx[BYTE_W-2];
              tx     <= {tx[BYTE_W-2:0], 1'b0};
            end
          end
          ST_RD_ACK: begin
            cnt <= '0;
            if (nack) begin
              sda_oe <= 1'b0;
              state  <= ST_SKIP;
            end else begin
              tx     <= rd_byte;
              sda_oe <= ~rd_byte[BYTE_W-1];
              state  <= ST_RD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R6: the line is only ever pulled down while SCL is low
  a_r6_oe_rise_scl_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_lvl);
  // R2: a START always leads to address collection
  a_r2_start_to_addr: assert property (@(posedge clk) disable iff (rst)
    start_p |=> (state == ST_ADDR));
  // R9: a STOP returns to idle with SDA released
  a_r9_stop_release: assert property (@(posedge clk) disable iff (rst)
    stop_p |=> (state == ST_IDLE && !sda_oe));
  // R3 and R7: an ignoring slave never drives the bus
  a_r3_skip_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SKIP) |-> !sda_oe);
  // R4: the write strobe lasts one cycle
  a_r4_strobe_single: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_slv_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [6:0]        DEV_ADDR    = 7'h1C,
  parameter logic [BYTE_W-1:0] REV_ADDR    = 8'hFF,
  parameter logic [BYTE_W-1:0] REV_VALUE   = 8'h43
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [BYTE_W-1:0] reg_rdata
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, sda_rise, sda_fall;
  logic start_p, stop_p;
  logic [BYTE_W-1:0] rd_byte;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_i), .sda_in(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .sda_rise(sda_rise), .sda_fall(sda_fall)
  );

  i2c_bus_cond u_cond (
    .clk(clk), .rst(rst), .scl_lvl(scl_lvl), .scl_fall(scl_fall),
    .sda_rise(sda_rise), .sda_fall(sda_fall),
    .start_p(start_p), .stop_p(stop_p)
  );

  // revision register overlays the external bank at one pointer value
  assign rd_byte = (reg_addr == REV_ADDR) ? REV_VALUE : reg_rdata;

  i2c_xfer_fsm #(.DEV_ADDR(DEV_ADDR), .REV_ADDR(REV_ADDR)) u_fsm (
    .clk(clk), .rst(rst), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p), .rd_byte(rd_byte),
    .sda_oe(sda_oe), .ptr(reg_addr), .wr_data(reg_wdata), .wr_stb(reg_we)
  );

  // R11: the revision register is never written
  a_r11_rev_protected: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> (reg_addr != REV_ADDR));
endmodule

// File: tb/i2c_reg_slave_bench.sv
`timescale 1ns/1ps
module i2c_reg_slave_bench;
  localparam int Q = 16;
  localparam logic [7:0] DEVW = 8'h38;  // 7'h1C, write
  localparam logic [7:0] DEVR = 8'h39;  // 7'h1C, read
  localparam int NV = 7;
  // {pointer, written value, expected readback}
  localparam logic [23:0] VEC [NV] = '{
    24'h10A5A5, 24'h113C3C, 24'h00FFFF, 24'h7F0101,
    24'h808080, 24'hFE5555, 24'hFF1243
  };

  logic clk = 1'b0, rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, reg_we, sda_bus;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] mem [256];
  logic [7:0] rbuf [4];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;
  assign reg_rdata = mem[reg_addr];
  always_ff @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

  i2c_reg_slave u_i2c_reg_slave (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic m_start();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(2);
  endtask

  task automatic m_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic m_bit(input logic b);
    tick(2); m_sda = b; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_scl = 1'b0;
  endtask

  task automatic m_send(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) m_bit(b[i]);
    tick(2); m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q/2);
    ack = !sda_bus; tick(Q/2);
    m_scl = 1'b0; tick(2);
  endtask

  task automatic m_recv(output logic [7:0] b, input bit last);
    bit steady = 1'b1;
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      m_scl = 1'b1; tick(Q/2);
      b[i] = sda_bus; tick(Q/2 - 1);
      if (sda_bus != b[i]) steady = 1'b0;
      m_scl = 1'b0;
    end
    chk(steady, "R6 sda stable in high", {7'd0, steady}, 8'h01);
    tick(2); m_sda = last; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_scl = 1'b0; tick(2);
    m_sda = 1'b1;
  endtask

  task automatic write_burst(input logic [7:0] p, input logic [7:0] d0, d1, d2, input int n);
    bit a;
    logic [7:0] d [3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    m_start();
    m_send(DEVW, a); chk(a, "R2 addr ack", {7'd0, a}, 8'h01);
    m_send(p, a);    chk(a, "R4 ptr ack", {7'd0, a}, 8'h01);
    for (int i = 0; i < n; i++) begin
      m_send(d[i], a); chk(a, "R4 data ack", {7'd0, a}, 8'h01);
    end
    m_stop();
  endtask

  task automatic read_burst(input logic [7:0] p, input int n);
    bit a;
    m_start();
    m_send(DEVW, a);
    m_send(p, a);
    m_start();  // repeated start, R8
    m_send(DEVR, a); chk(a, "R8 read addr ack", {7'd0, a}, 8'h01);
    for (int i = 0; i < n; i++) m_recv(rbuf[i], i == n - 1);
    tick(Q);
    chk(!sda_oe, "R7 released after nack", {7'd0, sda_oe}, 8'h00);
    m_stop();
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired (all requirements)");
    finish_up();
  end

  initial begin
    bit a;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    tick(5);
    rst = 1'b0;
    tick(2);
    // R1 reset state
    chk(!sda_oe, "R1 sda_oe", {7'd0, sda_oe}, 8'h00);
    chk(!reg_we, "R1 reg_we", {7'd0, reg_we}, 8'h00);
    chk(reg_addr == 8'h00, "R1 reg_addr", reg_addr, 8'h00);

    // vector table: single writes then single reads (R4, R11)
    for (int v = 0; v < NV; v++)
      write_burst(VEC[v][23:16], VEC[v][15:8], 8'h00, 8'h00, 1);
    for (int v = 0; v < NV; v++) begin
      read_burst(VEC[v][23:16], 1);
      chk(rbuf[0] == VEC[v][7:0], "R4/R11 table readback", rbuf[0], VEC[v][7:0]);
    end

    // R5 burst write and read with increment
    write_burst(8'h20, 8'hC1, 8'h62, 8'h0F, 3);
    read_burst(8'h20, 3);
    chk(rbuf[0] == 8'hC1, "R5 burst 0", rbuf[0], 8'hC1);
    chk(rbuf[1] == 8'h62, "R5 burst 1", rbuf[1], 8'h62);
    chk(rbuf[2] == 8'h0F, "R5 burst 2", rbuf[2], 8'h0F);

    // R5 wrap through the revision register (R11)
    write_burst(8'hFE, 8'h9A, 8'hEE, 8'h5B, 3);
    read_burst(8'hFE, 3);
    chk(rbuf[0] == 8'h9A, "R5 wrap FE", rbuf[0], 8'h9A);
    chk(rbuf[1] == 8'h43, "R11 rev after write", rbuf[1], 8'h43);
    chk(rbuf[2] == 8'h5B, "R5 wrap to 00", rbuf[2], 8'h5B);

    // R3 wrong device address: no ack, bytes ignored
    m_start();
    m_send(8'h54, a); chk(!a, "R3 no addr ack", {7'd0, a}, 8'h00);
    m_send(8'h10, a); chk(!a, "R3 no ptr ack", {7'd0, a}, 8'h00);
    m_send(8'h99, a); chk(!a, "R3 no data ack", {7'd0, a}, 8'h00);
    m_stop();
    read_burst(8'h10, 1);
    chk(rbuf[0] == 8'hA5, "R3 register untouched", rbuf[0], 8'hA5);

    // R9 STOP in mid data byte
    write_burst(8'h30, 8'h5A, 8'h00, 8'h00, 1);
    m_start();
    m_send(DEVW, a);
    m_send(8'h30, a);
    m_bit(1'b1); m_bit(1'b1); m_bit(1'b0); m_bit(1'b0);
    tick(2);
    m_stop();
    tick(4);
    chk(!sda_oe, "R9 released after stop", {7'd0, sda_oe}, 8'h00);
    read_burst(8'h30, 1);
    chk(rbuf[0] == 8'h5A, "R9 aborted byte not written", rbuf[0], 8'h5A);

    // R10 STOP in the same SCL high pulse as START is ignored
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b0; tick(Q);
    m_send(DEVW, a); chk(a, "R10 still addressed", {7'd0, a}, 8'h01);
    m_send(8'h40, a);
    m_send(8'h77, a);
    m_stop();
    read_burst(8'h40, 1);
    chk(rbuf[0] == 8'h77, "R10 write landed", rbuf[0], 8'h77);

    finish_up();
  end
endmodule